// File: doc/BRIEF.md
# Slow-bus clock stretcher

This block makes the processor clock for a system that mixes fast memory with a 1 MHz peripheral bus. A single 4 MHz system clock drives everything; a four-step phase counter derives a 2 MHz clock and the 1 MHz bus clock from it, so the design is fully synchronous. For ordinary accesses the processor clock follows the 2 MHz clock. When the address decoder flags the slow region, the high phase of the processor clock is stretched until the 1 MHz and 2 MHz clocks fall together. This keeps the processor in step with the slow bus.

Because of that hold, a slow cycle that starts while the 1 MHz clock is already high strobes the peripheral at once and again on the next 1 MHz high phase. For registers whose flags clear on read or write, that second access can lose an interrupt. The block marks every repeated strobe with a flag. An optional input gates such repeats off, so each processor cycle reaches the peripheral only once.

Top module: `slow_bus_stretcher`

## Requirements
- R1: After reset the phase counter steps 0,1,2,3,0,... once per system clock; `bus_clk_o` is high in phases 0 and 1 and low in phases 2 and 3; the internal 2 MHz clock is high in phases 1 and 3.
- R2: For a cycle not in the slow region, `phi_o` is high for exactly one system clock (phase 1 or 3) and low for exactly one (phase 0 or 2).
- R3: `slow_sel_i` and `rw_i` are sampled only on the system clock edge where `phi_o` rises; later changes have no effect on that cycle.
- R4: In a slow cycle `phi_o` falls only on entry to phase 2, where both derived clocks fall together, and only after at least MIN_HOLD (default 2) clocks high. So it stays high 3 clocks when it rises into phase 3 and 5 clocks when it rises into phase 1.
- R5: `per_stb_o` is a one-clock pulse in phase 0 of a stretched high time. When the slow cycle rises into phase 1 it also fires at once in that rising clock.
- R6: `second_o` is high for one clock on each strobe after the first in the same processor cycle, whether or not that strobe is suppressed.
- R7: With `suppress_i` high, every strobe after the first in a processor cycle is kept off `per_stb_o`; the first still fires.
- R8: `per_we_o` holds the `rw_i` value sampled at the rise (1 = write) for the whole slow cycle.
- R9: `per_stb_o` and `second_o` stay low in cycles outside the slow region.
- R10: While `rst_ni` is low, `phi_o`, `per_stb_o` and `second_o` are low and any stretch in progress is dropped at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 MHz system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| slow_sel_i | input | 1 | address decoded to the slow peripheral region |
| rw_i | input | 1 | access direction, 1 = write |
| suppress_i | input | 1 | gate off repeated peripheral strobes |
| phi_o | output | 1 | stretched processor clock |
| bus_clk_o | output | 1 | 1 MHz peripheral bus clock |
| per_stb_o | output | 1 | peripheral access strobe |
| per_we_o | output | 1 | direction of the current slow access |
| second_o | output | 1 | marks a repeated strobe in one processor cycle |

## Verification
The bench runs a stream of fast cycles to fix the phase pattern and the plain 2:1 clock shape. It then runs slow cycles that rise into phase 3 and into phase 1. The first gives a three-clock stretch with a single strobe. The second gives a five-clock stretch with the duplicate strobe, which tells the coincident-edge rule apart from a plain "wait for the next 1 MHz fall". The duplicate case is repeated with suppression on and off to show that the flag stays and only the strobe is removed. A reset in mid-stretch shows that a held clock is released and the next cycle is a plain one.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {PH_0 = 2'd0, PH_1 = 2'd1, PH_2 = 2'd2, PH_3 = 2'd3} sbs_phase_e;

  // both derived clocks fall on entry to this phase
  localparam sbs_phase_e PH_COINCIDE = PH_2;

  function automatic logic fast_clk_high(sbs_phase_e p);
    return p[0];
  endfunction

  function automatic logic bus_clk_high(sbs_phase_e p);
    return ~p[1];
  endfunction
endpackage

// File: rtl/sbs_phase_gen.sv
module sbs_phase_gen
  import sbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output sbs_phase_e ph_o,
  output sbs_phase_e ph_next_o,
  output logic       bus_clk_o
);
  sbs_phase_e ph_q;

  assign ph_next_o = sbs_phase_e'(ph_q + 2'd1);
  assign ph_o      = ph_q;
  assign bus_clk_o = bus_clk_high(ph_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph_q <= PH_0;
    else         ph_q <= ph_next_o;
endmodule

// File: rtl/sbs_stretch_fsm.sv
module sbs_stretch_fsm
  import sbs_pkg::*;
#(
  parameter int MIN_HOLD = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sbs_phase_e ph_next_i,
  input  logic       slow_sel_i,
  input  logic       rw_i,
  output logic       phi_o,
  output logic       slow_o,
  output logic       we_o,
  output logic       first_hi_o
);
  localparam int HI_W = $clog2(MIN_HOLD + 1);
  localparam logic [HI_W-1:0] HI_MAX = HI_W'(MIN_HOLD);

  logic            phi_q, slow_q, we_q;
  logic [HI_W-1:0] hi_q;
  logic            fall;

  always_comb begin
    if (!slow_q) fall = ~fast_clk_high(ph_next_i);
    else         fall = (ph_next_i == PH_COINCIDE) && (hi_q >= HI_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi_q  <= 1'b0;
      slow_q <= 1'b0;
      we_q   <= 1'b0;
      hi_q   <= '0;
    end else if (!phi_q) begin
      if (fast_clk_high(ph_next_i)) begin
        phi_q  <= 1'b1;
        slow_q <= slow_sel_i;
        we_q   <= rw_i;
        hi_q   <= HI_W'(1);
      end
    end else if (fall) begin
      phi_q  <= 1'b0;
      slow_q <= 1'b0;
    end else if (hi_q != HI_MAX) begin
      hi_q <= hi_q + HI_W'(1);
    end
  end

  assign phi_o      = phi_q;
  assign slow_o     = slow_q;
  assign we_o       = we_q;
  assign first_hi_o = phi_q && (hi_q == HI_W'(1));
endmodule

// File: rtl/sbs_strobe_gate.sv
module sbs_strobe_gate
  import sbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sbs_phase_e ph_i,
  input  logic       phi_i,
  input  logic       slow_i,
  input  logic       first_hi_i,
  input  logic       suppress_i,
  output logic       stb_o,
  output logic       second_o
);
  logic raw, seen_q;

  // bus clock rising edge, or immediate access when the cycle opens in bus-high
  assign raw = phi_i && slow_i &&
               ((ph_i == PH_0) || (ph_i == PH_1 && first_hi_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     seen_q <= 1'b0;
    else if (!phi_i) seen_q <= 1'b0;
    else if (raw)    seen_q <= 1'b1;

  assign second_o = raw && seen_q;
  assign stb_o    = raw && !(suppress_i && seen_q);
endmodule

// File: rtl/slow_bus_stretcher.sv
module slow_bus_stretcher
  import sbs_pkg::*;
#(
  parameter int MIN_HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_sel_i,
  input  logic rw_i,
  input  logic suppress_i,
  output logic phi_o,
  output logic bus_clk_o,
  output logic per_stb_o,
  output logic per_we_o,
  output logic second_o
);
  sbs_phase_e ph, ph_next;
  logic       slow_q, first_hi;

  sbs_phase_gen u_phase (
    .clk_i, .rst_ni,
    .ph_o      (ph),
    .ph_next_o (ph_next),
    .bus_clk_o (bus_clk_o)
  );

  sbs_stretch_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
    .clk_i, .rst_ni,
    .ph_next_i  (ph_next),
    .slow_sel_i (slow_sel_i),
    .rw_i       (rw_i),
    .phi_o      (phi_o),
    .slow_o     (slow_q),
    .we_o       (per_we_o),
    .first_hi_o (first_hi)
  );

  sbs_strobe_gate u_gate (
    .clk_i, .rst_ni,
    .ph_i       (ph),
    .phi_i      (phi_o),
    .slow_i     (slow_q),
    .first_hi_i (first_hi),
    .suppress_i (suppress_i),
    .stb_o      (per_stb_o),
    .second_o   (second_o)
  );
endmodule

module slow_bus_stretcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic suppress_i,
  input logic phi_o,
  input logic bus_clk_o,
  input logic per_stb_o,
  input logic per_we_o,
  input logic second_o,
  input logic slow_act_i
);
  assert_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi_o && !slow_act_i) |=> !phi_o);
  assert_low_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi_o) |=> phi_o);
  assert_coincident_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(phi_o) && $past(slow_act_i)) |-> $fell(bus_clk_o));
  assert_stb_in_slow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o || second_o) |-> (phi_o && slow_act_i));
  assert_stb_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_stb_o |=> !per_stb_o);
  assert_suppress_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suppress_i && second_o) |-> !per_stb_o);
  assert_we_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi_o && $past(phi_o)) |-> $stable(per_we_o));
endmodule

bind slow_bus_stretcher slow_bus_stretcher_chk u_chk (
  .clk_i, .rst_ni, .suppress_i, .phi_o, .bus_clk_o,
  .per_stb_o, .per_we_o, .second_o,
  .slow_act_i (slow_q)
);

// File: tb/slow_bus_stretcher_test.sv
module slow_bus_stretcher_test;
  logic clk = 1'b0;
  logic rst_ni, slow_sel, rw, suppress;
  logic phi, bus_clk, stb, we, second;
  int   n_chk = 0, n_fail = 0;
  int   bph = 0;

  always #4 clk = ~clk;

  slow_bus_stretcher uut (
    .clk_i (clk), .rst_ni (rst_ni), .slow_sel_i (slow_sel), .rw_i (rw),
    .suppress_i (suppress), .phi_o (phi), .bus_clk_o (bus_clk),
    .per_stb_o (stb), .per_we_o (we), .second_o (second)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (phase %0d, t=%0t)", req, act, exp, bph, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    bph = (bph + 1) % 4;
  endtask

  task automatic align(input int p);
    for (int g = 0; g < 16 && !(bph == p && phi == 1'b0); g++) step();
    chk("R2 align", {7'd0, phi}, 8'd0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; slow_sel = 1'b0; rw = 1'b0; suppress = 1'b0;
    #10;
    chk("R10 phi in reset", {7'd0, phi}, 8'd0);
    chk("R10 strobe in reset", {6'd0, stb, second}, 8'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    bph = 0;
  endtask

  // R1 R2 R9: fast stream
  task automatic test_fast();
    slow_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R2 fast phi", {7'd0, phi}, {7'd0, bph[0]});
      chk("R1 bus clock", {7'd0, bus_clk}, {7'd0, bph < 2});
      chk("R9 no strobe", {6'd0, stb, second}, 8'd0);
    end
  endtask

  // slow cycle opened from phase p_low; expected bit i applies i clocks after the rise
  task automatic test_slow(input string tag, input int p_low, input logic wr, input logic sup,
                           input int n, input logic [7:0] e_phi, input logic [7:0] e_stb,
                           input logic [7:0] e_sec);
    align(p_low);
    slow_sel = 1'b1; rw = wr; suppress = sup;
    step();
    slow_sel = 1'b0; rw = ~wr;  // R3: changes after the rise are ignored
    for (int i = 0; i < n; i++) begin
      chk({tag, " R4 phi"}, {7'd0, phi}, {7'd0, e_phi[i]});
      chk({tag, " R5 R7 strobe"}, {7'd0, stb}, {7'd0, e_stb[i]});
      chk({tag, " R6 second"}, {7'd0, second}, {7'd0, e_sec[i]});
      if (phi) chk({tag, " R8 R3 we"}, {7'd0, we}, {7'd0, wr});
      step();
    end
    suppress = 1'b0;
  endtask

  task automatic test_reset_mid();
    align(0);
    slow_sel = 1'b1;
    step();
    slow_sel = 1'b0;
    step();
    chk("R10 stretch active", {7'd0, phi}, 8'd1);
    #1 rst_ni = 1'b0;
    #1 chk("R10 async drop", {6'd0, phi, stb}, 8'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    bph = 0;
    step();
    chk("R10 post-reset rise", {7'd0, phi}, 8'd1);
    step();
    chk("R10 no leftover stretch", {7'd0, phi}, 8'd0);
  endtask

  initial begin
    #(8 * 5000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    test_fast();
    // rise into phase 3: 3 clocks high, single strobe in phase 0
    test_slow("p3", 2, 1'b1, 1'b0, 4, 8'b0111, 8'b0010, 8'b0000);
    // rise into phase 1: 5 clocks high, immediate plus repeated strobe
    test_slow("p1", 0, 1'b0, 1'b0, 6, 8'b011111, 8'b001001, 8'b001000);
    // same, repeat suppressed but still flagged
    test_slow("p1sup", 0, 1'b1, 1'b1, 6, 8'b011111, 8'b000001, 8'b001000);
    // suppress on a single-strobe cycle keeps the first strobe
    test_slow("p3sup", 2, 1'b0, 1'b1, 4, 8'b0111, 8'b0010, 8'b0000);
    test_fast();
    test_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule